// File: doc/BRIEF.md
# EDH flag port sequencer

This block sits at the flag side of an EDH processor. Each time a packet has been decoded, it captures the three 5-bit error-flag groups of that packet and sends them over a narrow bus to a downstream EDH processor. The bus is a 5-bit flag word plus a 2-bit group selector. The selector steps through the ancillary, full-field and active-picture groups in a fixed order. Each word stays on the bus for two clocks, so a receiver placed far away can sample it with margin.

Between packets the port parks on the ancillary group. The port drives its pins only in export mode. Export mode is entered by raising the read/write control first and the map-mode control afterwards. An output-enable then tells the pad logic to turn the pins around. While the EDH core is bypassed, the flag word reads as zero.

Top module: `edh_flag_port`

## Requirements
- R1: After the packet-decoded strobe is sampled at a rising edge, the selector shows 01, then 00, then 10, starting in the cycle after that edge. This runs whether the output-enable is high or not.
- R2: The selector never takes the value 11.
- R3: Each selector value and its flag word stay unchanged for HOLD_CYC consecutive cycles (default 2).
- R4: When no sequence is running, the selector shows 01 and the flag word is the ancillary word of the most recent packet. Before any packet has arrived, that word is all zeros.
- R5: Selector 01 carries the ancillary word, 00 the full-field word and 10 the active-picture word. The three words are captured at the strobe edge. Later changes on the flag inputs without a strobe have no effect.
- R6: Export needs read/write high at a clock edge where map mode is still low, with read/write then kept high while map mode rises. If both controls rise together, export stays off until map mode is dropped and raised again.
- R7: The output-enable rises OE_DLY cycles (default 2) after the export condition first holds at a rising edge. It falls in the same cycle that map mode or read/write drops.
- R8: A strobe that arrives while a sequence is running does not disturb it. Its words are held, and their sequence starts in the cycle right after the second 10 cycle. If several strobes arrive during one sequence, the latest one wins.
- R9: While bypass is high, the flag word is all zeros and the selector keeps stepping.
- R10: During and right after reset, the selector is 01, the flag word is zero and the output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output pixel clock; all updates on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| map_mode_i | input | 1 | Map-mode request |
| rw_i | input | 1 | Read/write control, high for export |
| bypass_i | input | 1 | EDH core bypassed; forces the flag word to zero |
| pkt_done_i | input | 1 | One-cycle strobe: flag groups of a packet are valid |
| anc_flags_i | input | 5 | Ancillary flag word |
| ff_flags_i | input | 5 | Full-field flag word |
| ap_flags_i | input | 5 | Active-picture flag word |
| sel_o | output | 2 | Group selector |
| flags_o | output | 5 | Flag word for the selected group |
| oe_o | output | 1 | Drive enable for the selector and flag pins |

## Verification
The bench drives inputs and samples outputs on falling edges. A strobe set before a rising edge produces the first 01 word at the next falling edge. Each following word pair is then due exactly two falling edges later.

A held strobe is expected at the falling edge right after the second 10 sample. The output-enable is expected low one sample and high two samples after map mode rises. Its drop and the bypass zeroing are combinational, so they are checked one nanosecond after the input change, before any clock edge.

// File: rtl/edh_fp_pkg.sv
package edh_fp_pkg;
  localparam int FLAG_W = 5;
  localparam int SEL_W  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ANC  = 2'd1,
    ST_FF   = 2'd2,
    ST_AP   = 2'd3
  } fp_state_e;

  localparam logic [SEL_W-1:0] SEL_ANC = 2'b01;
  localparam logic [SEL_W-1:0] SEL_FF  = 2'b00;
  localparam logic [SEL_W-1:0] SEL_AP  = 2'b10;

  typedef struct packed {
    logic [FLAG_W-1:0] anc;
    logic [FLAG_W-1:0] ff;
    logic [FLAG_W-1:0] ap;
  } flag_set_t;
endpackage

// File: rtl/edh_fp_enable.sv
module edh_fp_enable #(
  parameter int OE_DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic map_i,
  input  logic rw_i,
  output logic oe_o
);
  localparam int CW = (OE_DLY < 1) ? 1 : $clog2(OE_DLY + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(OE_DLY);

  logic          arm_q;
  logic [CW-1:0] cnt_q;
  logic          cond;

  // armed only if rw was seen high while map was still low
  assign cond = map_i & rw_i & arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (!rw_i)       arm_q <= 1'b0;
      else if (!map_i) arm_q <= 1'b1;
      if (!cond)                 cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign oe_o = cond & (cnt_q == CNT_MAX);

  p_oe_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(map_i && rw_i) |-> !oe_o);
  p_rw_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> $past(rw_i));
endmodule

// File: rtl/edh_fp_seq.sv
module edh_fp_seq
  import edh_fp_pkg::*;
#(
  parameter int HOLD_CYC = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pkt_i,
  input  flag_set_t words_i,
  output fp_state_e state_o,
  output flag_set_t cur_o
);
  localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [HW-1:0] PH_LAST = HW'(HOLD_CYC - 1);

  fp_state_e state_q;
  logic [HW-1:0] ph_q;
  logic      pend_q;
  flag_set_t nxt_q, cur_q;
  logic      word_end, seq_free, start;

  assign word_end = (ph_q == PH_LAST);
  assign seq_free = (state_q == ST_IDLE) || (state_q == ST_AP && word_end);
  assign start    = seq_free && (pend_q || pkt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      pend_q  <= 1'b0;
      nxt_q   <= '0;
      cur_q   <= '0;
    end else if (start) begin
      state_q <= ST_ANC;
      ph_q    <= '0;
      cur_q   <= pend_q ? nxt_q : words_i;
      // held words go first; a strobe on the same edge becomes the new pending set
      if (pend_q && pkt_i) nxt_q <= words_i;
      else                 pend_q <= 1'b0;
    end else begin
      if (pkt_i) begin
        nxt_q  <= words_i;
        pend_q <= 1'b1;
      end
      if (state_q != ST_IDLE) begin
        if (word_end) begin
          ph_q <= '0;
          unique case (state_q)
            ST_ANC:  state_q <= ST_FF;
            ST_FF:   state_q <= ST_AP;
            default: state_q <= ST_IDLE;
          endcase
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  assign state_o = state_q;
  assign cur_o   = cur_q;

  p_pend_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> state_q != ST_IDLE);
  p_start_from_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ANC && $past(state_q) != ST_ANC) |->
      ($past(state_q) == ST_IDLE || $past(state_q) == ST_AP));
endmodule

// File: rtl/edh_fp_out.sv
module edh_fp_out
  import edh_fp_pkg::*;
(
  input  fp_state_e         state_i,
  input  flag_set_t         cur_i,
  input  logic              bypass_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] word;

  always_comb begin
    unique case (state_i)
      ST_FF: begin
        sel_o = SEL_FF;
        word  = cur_i.ff;
      end
      ST_AP: begin
        sel_o = SEL_AP;
        word  = cur_i.ap;
      end
      default: begin
        sel_o = SEL_ANC;
        word  = cur_i.anc;
      end
    endcase
  end

  assign flags_o = bypass_i ? '0 : word;
endmodule

// File: rtl/edh_flag_port.sv
module edh_flag_port
  import edh_fp_pkg::*;
#(
  parameter int HOLD_CYC = 2,
  parameter int OE_DLY   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              map_mode_i,
  input  logic              rw_i,
  input  logic              bypass_i,
  input  logic              pkt_done_i,
  input  logic [FLAG_W-1:0] anc_flags_i,
  input  logic [FLAG_W-1:0] ff_flags_i,
  input  logic [FLAG_W-1:0] ap_flags_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              oe_o
);
  flag_set_t words, cur;
  fp_state_e state;

  assign words = '{anc: anc_flags_i, ff: ff_flags_i, ap: ap_flags_i};

  edh_fp_enable #(.OE_DLY(OE_DLY)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .map_i (map_mode_i),
    .rw_i  (rw_i),
    .oe_o  (oe_o)
  );

  edh_fp_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pkt_i  (pkt_done_i),
    .words_i(words),
    .state_o(state),
    .cur_o  (cur)
  );

  edh_fp_out u_out (
    .state_i (state),
    .cur_i   (cur),
    .bypass_i(bypass_i),
    .sel_o   (sel_o),
    .flags_o (flags_o)
  );

  p_never_11_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o != 2'b11);
  p_ff_after_anc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == SEL_FF && $past(sel_o) != SEL_FF) |-> $past(sel_o) == SEL_ANC);
  p_ap_after_ff_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == SEL_AP && $past(sel_o) != SEL_AP) |-> $past(sel_o) == SEL_FF);

  if (HOLD_CYC >= 2) begin : g_hold_chk
    p_hold_two_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_o != $past(sel_o)) |=> $stable(sel_o));
  end
endmodule

// File: tb/tb_edh_flag_port.sv
module tb_edh_flag_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic map_mode = 1'b0, rw = 1'b0, bypass = 1'b0, pkt = 1'b0;
  logic [4:0] anc = '0, ff = '0, ap = '0;
  logic [1:0] sel;
  logic [4:0] flags;
  logic oe;
  int total = 0, bad = 0, sel11 = 0;
  bit done = 0;

  always #4 clk = ~clk;

  edh_flag_port dut (
    .clk_i(clk), .rst_ni(rst_n), .map_mode_i(map_mode), .rw_i(rw),
    .bypass_i(bypass), .pkt_done_i(pkt), .anc_flags_i(anc),
    .ff_flags_i(ff), .ap_flags_i(ap), .sel_o(sel), .flags_o(flags), .oe_o(oe)
  );

  // {anc, ff, ap}
  localparam logic [14:0] PKT_TAB [0:5] = '{
    {5'h01, 5'h02, 5'h04}, {5'h1f, 5'h00, 5'h15}, {5'h0a, 5'h15, 5'h1e},
    {5'h10, 5'h08, 5'h03}, {5'h00, 5'h1f, 5'h00}, {5'h13, 5'h0c, 5'h19}
  };

  task automatic tick; @(negedge clk); endtask

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b_%b expected=%b_%b", tag, act[6:5], act[4:0], exp[6:5], exp[4:0]);
    end
  endtask

  task automatic chk1(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // strobe at this negedge; return at the negedge after the sampling edge
  task automatic strobe(logic [14:0] w);
    pkt = 1'b1; {anc, ff, ap} = w;
    tick;
    pkt = 1'b0; {anc, ff, ap} = ~w;  // R5: later input changes must be ignored
  endtask

  // checks 6 samples, ends at the second 10 sample
  task automatic check_seq(string tag, logic [14:0] w);
    chk({tag, " R1 R5 anc0"}, {sel, flags}, {2'b01, w[14:10]}); tick;
    chk({tag, " R3 anc1"},    {sel, flags}, {2'b01, w[14:10]}); tick;
    chk({tag, " R1 R5 ff0"},  {sel, flags}, {2'b00, w[9:5]});   tick;
    chk({tag, " R3 ff1"},     {sel, flags}, {2'b00, w[9:5]});   tick;
    chk({tag, " R1 R5 ap0"},  {sel, flags}, {2'b10, w[4:0]});   tick;
    chk({tag, " R3 ap1"},     {sel, flags}, {2'b10, w[4:0]});
  endtask

  always @(negedge clk) if (rst_n && sel == 2'b11) sel11++;

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    tick; tick;
    chk("R10 reset sel/flags", {sel, flags}, {2'b01, 5'h00});
    chk1("R10 reset oe", oe, 1'b0);
    rst_n = 1'b1;
    tick; tick;
    chk("R4 idle before any packet", {sel, flags}, {2'b01, 5'h00});
    chk1("R10 oe low after reset", oe, 1'b0);

    // table walk
    for (int i = 0; i < 6; i++) begin
      strobe(PKT_TAB[i]);
      check_seq("table", PKT_TAB[i]);
      tick;
      chk("R4 idle anc of last packet", {sel, flags}, {2'b01, PKT_TAB[i][14:10]});
      tick; tick;
      chk("R4 idle stays", {sel, flags}, {2'b01, PKT_TAB[i][14:10]});
    end

    // R8: strobe during FF is held until AP completes
    strobe(PKT_TAB[0]);
    tick; tick;  // first FF sample
    pkt = 1'b1; {anc, ff, ap} = PKT_TAB[2];
    tick;
    pkt = 1'b0; {anc, ff, ap} = '0;
    chk("R8 running seq undisturbed ff", {sel, flags}, {2'b00, PKT_TAB[0][9:5]});
    tick;
    chk("R8 running seq ap0", {sel, flags}, {2'b10, PKT_TAB[0][4:0]});
    tick;
    chk("R8 running seq ap1", {sel, flags}, {2'b10, PKT_TAB[0][4:0]});
    tick;
    check_seq("R8 held", PKT_TAB[2]);

    // R8: strobe on the last AP cycle starts the next one immediately
    strobe(PKT_TAB[3]);
    check_seq("R8 back-to-back", PKT_TAB[3]);
    tick;

    // R8: two strobes mid-sequence, latest wins
    strobe(PKT_TAB[1]);
    pkt = 1'b1; {anc, ff, ap} = PKT_TAB[4]; tick;
    pkt = 1'b1; {anc, ff, ap} = PKT_TAB[5]; tick;
    pkt = 1'b0; {anc, ff, ap} = '0;
    tick; tick; tick;
    chk("R8 first seq still ap", {sel, flags}, {2'b10, PKT_TAB[1][4:0]});
    tick;
    check_seq("R8 latest wins", PKT_TAB[5]);
    tick;
    chk("R4 idle after latest", {sel, flags}, {2'b01, PKT_TAB[5][14:10]});

    // R9: bypass zeroes flags, selector keeps stepping
    bypass = 1'b1; #1;
    chk("R9 bypass idle", {sel, flags}, {2'b01, 5'h00});
    strobe(PKT_TAB[0]);
    tick; tick;
    chk("R9 bypass during ff", {sel, flags}, {2'b00, 5'h00});
    bypass = 1'b0; #1;
    chk("R9 bypass released", {sel, flags}, {2'b00, PKT_TAB[0][9:5]});
    tick; tick; tick; tick;

    // R6/R7: enable ordering and delay
    rw = 1'b1; tick;
    map_mode = 1'b1; tick;
    chk1("R7 oe low after 1 cycle", oe, 1'b0);
    tick;
    chk1("R7 oe high after 2 cycles", oe, 1'b1);
    tick;
    chk1("R7 oe stays high", oe, 1'b1);
    map_mode = 1'b0; #1;
    chk1("R7 oe drops with map", oe, 1'b0);
    map_mode = 1'b1; tick; tick;
    chk1("R7 oe back after 2", oe, 1'b1);
    rw = 1'b0; #1;
    chk1("R7 oe drops with rw", oe, 1'b0);
    map_mode = 1'b0; tick;
    rw = 1'b1; map_mode = 1'b1;
    tick; tick; tick; tick;
    chk1("R6 simultaneous rise stays off", oe, 1'b0);
    map_mode = 1'b0; tick;
    map_mode = 1'b1; tick; tick;
    chk1("R6 re-raise map enables", oe, 1'b1);

    chk1("R2 selector never 11", sel11 != 0, 1'b0);
    finish_up();
  end
endmodule